// File: doc/BRIEF.md
# External Bus Release Arbiter

This block sits on the bus-master side of an external memory interface. An outside device asks for the bus with an asynchronous request line. The arbiter waits until the internal bus sequencer reaches a point where the bus can be let go, and then hands the bus over with a registered grant. It never lets go in the middle of a burst such as a cache line fill or write-back. It also holds the bus between the read and the write of an atomic test-and-set, and between the cycles of one access split over a narrower bus. When the outside device withdraws its request, the grant is withdrawn. One idle clock is then kept before internal cycles restart, so the two masters never overlap.

While the bus is out, the arbiter asks for it back with a reclaim output whenever internal work is waiting. That work is a refresh that has not yet started, or an interrupt whose level is strictly above the current mask. The block also drives pull-up enables for the pads. The address pull-up runs for a fixed window after grant. The data pull-up is on whenever the sequencer will not be driving the data bus.

Top module: `bus_release_arbiter`

## Requirements
- R1: After reset all outputs are 0. The request passes a two-flop synchroniser, so grant can rise no earlier than the third rising edge after the request is applied. Grant changes only on rising edges.
- R2: Grant rises only on an edge where `seq_cycle_done_i` was 1 while the synchronised request was high. While it is 0, grant stays low.
- R3: Grant does not rise on an edge where `seq_burst_i` was 1.
- R4: Grant does not rise on an edge where `seq_atomic_i` was 1.
- R5: Grant does not rise on an edge where `seq_split_i` was 1.
- R6: Once the request is negated, grant falls on the third rising edge.
- R7: `released_o` is 1 from the edge where grant rises until one clock after grant falls. That extra clock is the idle guard cycle.
- R8: While grant is held, `reclaim_o` is 1 one edge after `refresh_pend_i` was 1.
- R9: While grant is held, `reclaim_o` is 1 one edge after `irq_level_i` was strictly greater than `irq_mask_i`. Both are 4-bit unsigned. Equal values do not reclaim.
- R10: `reclaim_o` is never 1 while grant is 0, and it falls on the same edge as grant.
- R11: If `addr_pu_en_i` is 1 at the edge where grant rises, `addr_pu_o` is 1 for exactly 4 clocks starting with that edge. It ends early if grant falls first. If the enable is 0 at that edge, the pull-up stays 0.
- R12: `data_pu_o` after each edge equals `data_pu_en_i AND NOT seq_drive_next_i` as sampled at that edge. The sequencer raises `seq_drive_next_i` one clock before it drives the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | 1 | Asynchronous bus release request from the outside device |
| seq_cycle_done_i | input | 1 | Sequencer is at a cycle boundary |
| seq_burst_i | input | 1 | Burst transfer in progress |
| seq_atomic_i | input | 1 | Atomic read-modify-write between its read and write |
| seq_split_i | input | 1 | Split narrow-bus access in progress |
| seq_drive_next_i | input | 1 | Sequencer drives the data bus on the next clock |
| refresh_pend_i | input | 1 | Refresh requested and not yet started |
| irq_level_i | input | 4 | Highest pending interrupt level |
| irq_mask_i | input | 4 | Interrupt mask level |
| addr_pu_en_i | input | 1 | Address pull-up enable setting |
| data_pu_en_i | input | 1 | Data pull-up enable setting |
| grant_o | output | 1 | Bus granted to the outside device |
| reclaim_o | output | 1 | Request for the bus to be handed back |
| released_o | output | 1 | Tells the sequencer the bus is not its own (includes guard clock) |
| addr_pu_o | output | 1 | Address pin pull-up active |
| data_pu_o | output | 1 | Data pin pull-up active |

## Verification
The address pull-up window and the reclaim request can both be live in the same cycle. The bench raises a pending refresh in the first clocks after grant. It also withdraws the request before the four-clock window ends, so that both functions are cut off by the grant falling. A behavioural model tracks the request pipeline, the window countdown and the reclaim condition on every clock. It judges that reclaim and pull-up switch on their own edges and both drop together with grant.

// File: rtl/brel_pkg.sv
package brel_pkg;
  typedef enum logic [1:0] {
    ST_OWN   = 2'd0,
    ST_REL   = 2'd1,
    ST_GUARD = 2'd2
  } brel_state_e;
endpackage

// File: rtl/brel_sync.sv
module brel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/brel_ctrl.sv
module brel_ctrl
  import brel_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_s_i,
  input  logic             cycle_done_i,
  input  logic             burst_i,
  input  logic             atomic_i,
  input  logic             split_i,
  input  logic             refresh_pend_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] irq_mask_i,
  output logic             grant_d_o,
  output logic             grant_o,
  output logic             released_o,
  output logic             reclaim_o
);
  brel_state_e state_q, state_d;
  logic        safe_point;
  logic        need_bus;

  // Safe only at a cycle end that is not inside an indivisible sequence.
  assign safe_point = cycle_done_i & ~burst_i & ~atomic_i & ~split_i;
  assign need_bus   = refresh_pend_i | (irq_level_i > irq_mask_i);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OWN:   if (req_s_i && safe_point) state_d = ST_REL;
      ST_REL:   if (!req_s_i)              state_d = ST_GUARD;
      ST_GUARD:                            state_d = ST_OWN;
      default:                             state_d = ST_OWN;
    endcase
  end

  assign grant_d_o = (state_d == ST_REL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OWN;
      grant_o    <= 1'b0;
      released_o <= 1'b0;
      reclaim_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      grant_o    <= grant_d_o;
      released_o <= (state_d != ST_OWN);
      reclaim_o  <= grant_d_o & need_bus;
    end
  end
endmodule

// File: rtl/brel_pullup.sv
module brel_pullup #(
  parameter int PU_CYCLES = 4,
  localparam int CW = $clog2(PU_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic grant_d_i,
  input  logic grant_q_i,
  input  logic addr_en_i,
  input  logic data_en_i,
  input  logic drive_next_i,
  output logic addr_pu_o,
  output logic data_pu_o
);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= '0;
      data_pu_o <= 1'b0;
    end else begin
      if (grant_d_i && !grant_q_i)
        win_q <= addr_en_i ? CW'(PU_CYCLES) : '0;
      else if (!grant_d_i)
        win_q <= '0;
      else if (win_q != '0)
        win_q <= win_q - 1'b1;
      data_pu_o <= data_en_i & ~drive_next_i;
    end
  end

  assign addr_pu_o = (win_q != '0);
endmodule

// File: rtl/bus_release_arbiter.sv
module bus_release_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 4,
  parameter int PU_CYCLES   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_req_i,
  input  logic             seq_cycle_done_i,
  input  logic             seq_burst_i,
  input  logic             seq_atomic_i,
  input  logic             seq_split_i,
  input  logic             seq_drive_next_i,
  input  logic             refresh_pend_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] irq_mask_i,
  input  logic             addr_pu_en_i,
  input  logic             data_pu_en_i,
  output logic             grant_o,
  output logic             reclaim_o,
  output logic             released_o,
  output logic             addr_pu_o,
  output logic             data_pu_o
);
  logic req_s;
  logic grant_d;

  brel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ext_req_i),
    .q_o (req_s)
  );

  brel_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_s_i        (req_s),
    .cycle_done_i   (seq_cycle_done_i),
    .burst_i        (seq_burst_i),
    .atomic_i       (seq_atomic_i),
    .split_i        (seq_split_i),
    .refresh_pend_i (refresh_pend_i),
    .irq_level_i    (irq_level_i),
    .irq_mask_i     (irq_mask_i),
    .grant_d_o      (grant_d),
    .grant_o        (grant_o),
    .released_o     (released_o),
    .reclaim_o      (reclaim_o)
  );

  brel_pullup #(.PU_CYCLES(PU_CYCLES)) u_pu (
    .clk          (clk),
    .rst          (rst),
    .grant_d_i    (grant_d),
    .grant_q_i    (grant_o),
    .addr_en_i    (addr_pu_en_i),
    .data_en_i    (data_pu_en_i),
    .drive_next_i (seq_drive_next_i),
    .addr_pu_o    (addr_pu_o),
    .data_pu_o    (data_pu_o)
  );
endmodule

// File: rtl/brel_chk.sv
module brel_chk (
  input logic clk,
  input logic rst,
  input logic seq_cycle_done_i,
  input logic seq_burst_i,
  input logic seq_atomic_i,
  input logic seq_split_i,
  input logic grant_o,
  input logic reclaim_o,
  input logic released_o,
  input logic addr_pu_o
);
  // R2
  grant_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_o) |-> $past(seq_cycle_done_i));
  // R3
  grant_not_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_o) |-> !$past(seq_burst_i));
  // R4
  grant_not_in_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_o) |-> !$past(seq_atomic_i));
  // R5
  grant_not_in_split_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_o) |-> !$past(seq_split_i));
  // R10
  reclaim_only_released_chk: assert property (@(posedge clk) disable iff (rst)
    reclaim_o |-> grant_o);
  // R7
  guard_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_o) |-> released_o);
  // R7
  guard_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (released_o && !grant_o) |=> !released_o);
  // R7
  released_covers_grant_chk: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> released_o);
  // R11
  addr_pu_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
    addr_pu_o |-> grant_o);
endmodule

bind bus_release_arbiter brel_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .seq_cycle_done_i (seq_cycle_done_i),
  .seq_burst_i      (seq_burst_i),
  .seq_atomic_i     (seq_atomic_i),
  .seq_split_i      (seq_split_i),
  .grant_o          (grant_o),
  .reclaim_o        (reclaim_o),
  .released_o       (released_o),
  .addr_pu_o        (addr_pu_o)
);

// File: tb/sim_bus_release_arbiter.sv
`timescale 1ns/1ps
module sim_bus_release_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req = 0, done = 0, burst = 0, atomic = 0, split = 0, drv_nxt = 0;
  logic refresh = 0, apu_en = 0, dpu_en = 0;
  logic [3:0] lvl = 0, mask = 0;
  logic grant, reclaim, released, apu, dpu;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  bus_release_arbiter u0 (
    .clk(clk), .rst(rst), .ext_req_i(ext_req),
    .seq_cycle_done_i(done), .seq_burst_i(burst), .seq_atomic_i(atomic),
    .seq_split_i(split), .seq_drive_next_i(drv_nxt), .refresh_pend_i(refresh),
    .irq_level_i(lvl), .irq_mask_i(mask), .addr_pu_en_i(apu_en),
    .data_pu_en_i(dpu_en), .grant_o(grant), .reclaim_o(reclaim),
    .released_o(released), .addr_pu_o(apu), .data_pu_o(dpu)
  );

  // Behavioural reference model
  bit m_s1, m_s2, m_grant, m_rel, m_recl, m_dpu;
  int m_phase, m_win;
  always @(posedge clk) begin
    int nph;
    bit ng;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_grant = 0; m_rel = 0; m_recl = 0; m_dpu = 0;
      m_phase = 0; m_win = 0;
    end else begin
      nph = m_phase;
      if (m_phase == 0 && m_s2 && done && !burst && !atomic && !split) nph = 1;
      else if (m_phase == 1 && !m_s2) nph = 2;
      else if (m_phase == 2) nph = 0;
      ng = (nph == 1);
      m_recl = ng && (refresh || (int'(lvl) > int'(mask)));
      if (ng && !m_grant) m_win = apu_en ? 4 : 0;
      else if (!ng) m_win = 0;
      else if (m_win > 0) m_win = m_win - 1;
      m_dpu = dpu_en && !drv_nxt;
      m_grant = ng;
      m_rel = (nph != 0);
      m_phase = nph;
      m_s2 = m_s1;
      m_s1 = ext_req;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done_run) begin
      chk("R2 grant model", grant, m_grant);
      chk("R7 released model", released, m_rel);
      chk("R8 reclaim model", reclaim, m_recl);
      chk("R11 addr pull-up model", apu, m_win > 0);
      chk("R12 data pull-up model", dpu, m_dpu);
    end
    if (cyc > 20000 && !done_run) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drop_req();
    ext_req = 0;
    step(3);
  endtask

  initial begin
    step(3);
    rst = 0;
    chk("R1 reset grant", grant, 0);
    chk("R1 reset reclaim", reclaim, 0);
    chk("R1 reset released", released, 0);
    chk("R1 reset pull-ups", apu | dpu, 0);

    // Basic release with address pull-up and reclaim overlap
    done = 1; apu_en = 1; ext_req = 1;
    step(2);
    chk("R1 grant held back by synchroniser", grant, 0);
    step(1);
    chk("R1 grant after third edge", grant, 1);
    chk("R11 address pull-up on", apu, 1);
    refresh = 1;
    step(1);
    chk("R8 reclaim on refresh", reclaim, 1);
    refresh = 0; lvl = 4'd5; mask = 4'd5;
    step(1);
    chk("R9 equal level no reclaim", reclaim, 0);
    lvl = 4'd6;
    step(1);
    chk("R9 higher level reclaims", reclaim, 1);
    step(2);
    chk("R11 window ended", apu, 0);
    ext_req = 0;
    step(2);
    chk("R6 grant still high", grant, 1);
    step(1);
    chk("R6 grant withdrawn", grant, 0);
    chk("R10 reclaim drops with grant", reclaim, 0);
    chk("R7 guard clock", released, 1);
    step(1);
    chk("R7 guard over", released, 0);
    step(2);
    chk("R10 no reclaim while owning", reclaim, 0);
    lvl = 0; mask = 0;

    // Burst blocks release
    burst = 1; ext_req = 1;
    step(8);
    chk("R3 held during burst", grant, 0);
    burst = 0;
    step(1);
    chk("R3 grant after burst", grant, 1);
    drop_req(); step(2);

    // Atomic blocks release
    atomic = 1; ext_req = 1;
    step(8);
    chk("R4 held during atomic", grant, 0);
    atomic = 0;
    step(1);
    chk("R4 grant after atomic", grant, 1);
    drop_req(); step(2);

    // Split access blocks release
    split = 1; ext_req = 1;
    step(8);
    chk("R5 held during split", grant, 0);
    split = 0;
    step(1);
    chk("R5 grant after split", grant, 1);
    drop_req(); step(2);

    // Cycle-not-done holds
    done = 0; ext_req = 1;
    step(6);
    chk("R2 held while cycle busy", grant, 0);
    done = 1;
    step(1);
    chk("R2 grant at cycle end", grant, 1);
    drop_req(); step(2);

    // Short grant truncates pull-up; refresh in same window
    ext_req = 1;
    step(1);
    ext_req = 0;
    refresh = 1;
    step(2);
    chk("R11 pull-up during short grant", apu, 1);
    step(1);
    chk("R11 pull-up cut with grant", apu, 0);
    chk("R10 reclaim cut with grant", reclaim, 0);
    refresh = 0;
    step(2);

    // Pull-up disabled at grant
    apu_en = 0; ext_req = 1;
    step(3);
    chk("R11 disabled pull-up stays low", apu, 0);
    drop_req(); step(2);

    // Data pull-up follows drive-next
    dpu_en = 1; drv_nxt = 0;
    step(1);
    chk("R12 data pull-up idle", dpu, 1);
    drv_nxt = 1;
    step(1);
    chk("R12 data pull-up off before drive", dpu, 0);
    drv_nxt = 0; dpu_en = 0;
    step(1);
    chk("R12 data pull-up disabled", dpu, 0);
    for (int i = 0; i < 12; i++) begin
      drv_nxt = i[0]; dpu_en = i[1];
      step(1);
    end
    step(2);

    done_run = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule